// File: doc/BRIEF.md
# Zcb Compressed Instruction Expander

This combinational unit takes one 16-bit instruction from the code-size-reduction subset of the compressed instruction set. It returns the equivalent full-width 32-bit RISC-V instruction word, or it raises an illegal flag. The subset covers byte and halfword loads and stores, the unary extend and complement operations, and the compressed multiply. The expanded word goes straight to an ordinary 32-bit decoder, so the rest of the pipeline only ever sees base, M and bit-manipulation encodings.

Three parameters set legality:
- `XLEN` (32 or 64) sets the datapath width.
- `EN_MUL` enables the multiply extension.
- `EN_BITMANIP` enables the bit-manipulation extension.

An encoding whose extension is disabled is flagged illegal. So is every 16-bit word outside the covered subset, including the other compressed instructions, which are handled by a different unit. On an illegal word the expanded output is forced to zero.

The unit does not check alignment, does not touch memory and does not execute anything.

Top module: `zcb_expander`

## Requirements
- R1: Every 3-bit register field `f` in the compressed word names architectural register `8 + f`, so only x8..x15 appear in the expanded word. The base or destination field is bits[9:7]. The second register field is bits[4:2].
- R2: With bits[1:0]=00 and bits[15:10]=100001, the word expands to a halfword load.
  - Bit 6 chooses the form: 0 gives lhu, 1 gives lh.
  - The byte offset is `2*bit5`.
  - rd is `8+bits[4:2]` and rs1 is `8+bits[9:7]`.
- R3: With bits[1:0]=00, bits[15:10]=100000 expands to lbu and 100010 expands to sb.
  - The byte offset is `2*bit5 + bit6` (range 0..3).
  - For sb, rs2 is `8+bits[4:2]`.
- R4: With bits[1:0]=00 and bits[15:10]=100011, the word expands to sh.
  - The offset is `2*bit5`.
  - rs2 is `8+bits[4:2]`.
  - If bit 6 is 1 the word is illegal.
- R5: With bits[1:0]=01, bits[15:10]=100111, bits[6:5]=11 and bits[4:2]=000, the word expands to `andi rd, rd, 255` with rd = `8+bits[9:7]`. This is legal in every configuration.
- R6: The same unary group with bits[4:2]=101 expands to `xori rd, rd, -1`. This is legal in every configuration.
- R7: In the unary group, bits[4:2]=001, 011 and 010 expand as follows:
  - 001 gives sext.b.
  - 011 gives sext.h.
  - 010 gives zext.h. It uses the OP major opcode (0110011) when `XLEN`=32 and the 32-bit-op major opcode (0111011) when `XLEN`=64.
  - All three are illegal when `EN_BITMANIP`=0.
- R8: In the unary group, bits[4:2]=100 expands to zext.w, written as `add.uw rd, rd, x0`. It is legal only when `XLEN`=64 and `EN_BITMANIP`=1, and illegal otherwise.
- R9: With bits[1:0]=01, bits[15:10]=100111 and bits[6:5]=10, the word expands to `mul rd, rd, rs2`, with rs2 = `8+bits[4:2]`. It is illegal when `EN_MUL`=0.
- R10: The following words are illegal:
  - unary sub-codes 110 and 111;
  - the all-zero word;
  - quadrant 2 or 3;
  - any other word outside the forms above.
  
  Whenever the illegal flag is 1, the expanded word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_word_i | input | 16 | Compressed instruction to expand |
| x_word_o | output | 32 | Expanded 32-bit instruction, zero when illegal |
| illegal_o | output | 1 | High when the compressed word is not a legal covered encoding in this configuration |

## Verification
The bench runs three configurations: 32-bit with everything enabled, 64-bit with everything enabled, and 32-bit with both extensions disabled. This makes each legality gate flip between an expansion and an illegal flag on the same input word.

The bench also targets the following corner cases:
- **Byte offset bit order.** Offset bits 6 and 5 swapped in the byte forms would give offsets 1 and 2 in each other's place.
- **Reserved halfword store.** Missing the bit-6 check on the halfword store would emit an sh for a reserved word.
- **zext.h opcode.** A single zext.h opcode for both widths would break one of them.
- **zext.w.** Gating zext.w on the bit-manipulation enable alone would let it through on a 32-bit datapath.
- **Register fields.** Wrong register bias would show up as x0..x7 in the expanded fields.

// File: rtl/zcb_pkg.sv
// Shared definitions for the Zcb expander: decoded operation kinds,
// 32-bit major opcodes, and the compressed-register mapping.
package zcb_pkg;

    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_LBU   = 4'd1,
        K_LHU   = 4'd2,
        K_LH    = 4'd3,
        K_SB    = 4'd4,
        K_SH    = 4'd5,
        K_ZEXTB = 4'd6,
        K_SEXTB = 4'd7,
        K_ZEXTH = 4'd8,
        K_SEXTH = 4'd9,
        K_ZEXTW = 4'd10,
        K_NOT   = 4'd11,
        K_MUL   = 4'd12
    } zcb_kind_e;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_OP32  = 7'b0111011;

    localparam int CREG_W = 3;
    localparam int XREG_W = 5;

    // Map a 3-bit compressed register field onto x8..x15.
    function automatic logic [XREG_W-1:0] creg(input logic [CREG_W-1:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic is_mem_kind(input zcb_kind_e k);
        return (k == K_LBU) || (k == K_LHU) || (k == K_LH) ||
               (k == K_SB) || (k == K_SH);
    endfunction

endpackage

// File: rtl/zcb_field_decode.sv
// Classifies a 16-bit compressed word into one operation kind and
// extracts its register fields and byte offset. Encodings whose
// extension is disabled by parameter come out as K_NONE.
// Assumes: XLEN is 32 or 64; purely combinational.
module zcb_field_decode
    import zcb_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit EN_MUL      = 1'b1,
    parameter bit EN_BITMANIP = 1'b1
) (
    input  logic [15:0]         c_word,
    output zcb_kind_e           kind,
    output logic [CREG_W-1:0]   reg_a,
    output logic [CREG_W-1:0]   reg_b,
    output logic [1:0]          off
);
    localparam bit HAS64 = (XLEN == 64);

    logic [5:0] funct6;
    logic [1:0] quad;
    logic [1:0] sub2;
    logic [2:0] sub3;

    // Slice the fixed fields of the compressed word.
    always_comb begin
        funct6 = c_word[15:10];
        quad   = c_word[1:0];
        sub2   = c_word[6:5];
        sub3   = c_word[4:2];
        reg_a  = c_word[9:7];
        reg_b  = c_word[4:2];
    end

    // Select the operation kind, applying configuration legality.
    always_comb begin
        kind = K_NONE;
        if (quad == 2'b00) begin
            unique case (funct6)
                6'b100000: kind = K_LBU;
                6'b100001: kind = sub2[1] ? K_LH : K_LHU;
                6'b100010: kind = K_SB;
                6'b100011: kind = sub2[1] ? K_NONE : K_SH;
                default:   kind = K_NONE;
            endcase
        end else if (quad == 2'b01 && funct6 == 6'b100111) begin
            if (sub2 == 2'b10) begin
                kind = EN_MUL ? K_MUL : K_NONE;
            end else if (sub2 == 2'b11) begin
                unique case (sub3)
                    3'b000:  kind = K_ZEXTB;
                    3'b001:  kind = EN_BITMANIP ? K_SEXTB : K_NONE;
                    3'b010:  kind = EN_BITMANIP ? K_ZEXTH : K_NONE;
                    3'b011:  kind = EN_BITMANIP ? K_SEXTH : K_NONE;
                    3'b100:  kind = (EN_BITMANIP && HAS64) ? K_ZEXTW : K_NONE;
                    3'b101:  kind = K_NOT;
                    default: kind = K_NONE;
                endcase
            end
        end
    end

    // Byte forms use {bit5,bit6}; halfword forms use bit5 only.
    always_comb begin
        if (kind == K_LBU || kind == K_SB) off = {c_word[5], c_word[6]};
        else                               off = {c_word[5], 1'b0};
    end
endmodule

// File: rtl/zcb_mem_form.sv
// Builds the 32-bit load or store word for the memory kinds.
// Assumes: kind is one of the memory kinds when the result is used.
module zcb_mem_form
    import zcb_pkg::*;
(
    input  zcb_kind_e           kind,
    input  logic [CREG_W-1:0]   reg_a,
    input  logic [CREG_W-1:0]   reg_b,
    input  logic [1:0]          off,
    output logic [31:0]         word
);
    logic [XREG_W-1:0] base_r;
    logic [XREG_W-1:0] data_r;
    logic [11:0]       imm;

    // Register and immediate operands shared by all memory forms.
    always_comb begin
        base_r = creg(reg_a);
        data_r = creg(reg_b);
        imm    = {10'b0, off};
    end

    // Assemble the I-type load or S-type store.
    always_comb begin
        unique case (kind)
            K_LBU:   word = {imm, base_r, 3'b100, data_r, OPC_LOAD};
            K_LHU:   word = {imm, base_r, 3'b101, data_r, OPC_LOAD};
            K_LH:    word = {imm, base_r, 3'b001, data_r, OPC_LOAD};
            K_SB:    word = {imm[11:5], data_r, base_r, 3'b000, imm[4:0], OPC_STORE};
            K_SH:    word = {imm[11:5], data_r, base_r, 3'b001, imm[4:0], OPC_STORE};
            default: word = 32'b0;
        endcase
    end
endmodule

// File: rtl/zcb_arith_form.sv
// Builds the 32-bit word for the unary and multiply kinds. Destination
// and first source are the same register.
// Assumes: XLEN is 32 or 64; zext.h opcode depends on it.
module zcb_arith_form
    import zcb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  zcb_kind_e           kind,
    input  logic [CREG_W-1:0]   reg_a,
    input  logic [CREG_W-1:0]   reg_b,
    output logic [31:0]         word
);
    localparam logic [6:0] ZEXTH_OPC = (XLEN == 64) ? OPC_OP32 : OPC_OP;

    logic [XREG_W-1:0] rd_r;
    logic [XREG_W-1:0] rs2_r;

    // Register operands.
    always_comb begin
        rd_r  = creg(reg_a);
        rs2_r = creg(reg_b);
    end

    // Assemble the arithmetic instruction.
    always_comb begin
        unique case (kind)
            K_ZEXTB: word = {12'h0FF, rd_r, 3'b111, rd_r, OPC_OPIMM};
            K_NOT:   word = {12'hFFF, rd_r, 3'b100, rd_r, OPC_OPIMM};
            K_SEXTB: word = {7'b0110000, 5'b00100, rd_r, 3'b001, rd_r, OPC_OPIMM};
            K_SEXTH: word = {7'b0110000, 5'b00101, rd_r, 3'b001, rd_r, OPC_OPIMM};
            K_ZEXTH: word = {7'b0000100, 5'b00000, rd_r, 3'b100, rd_r, ZEXTH_OPC};
            K_ZEXTW: word = {7'b0000100, 5'b00000, rd_r, 3'b000, rd_r, OPC_OP32};
            K_MUL:   word = {7'b0000001, rs2_r, rd_r, 3'b000, rd_r, OPC_OP};
            default: word = 32'b0;
        endcase
    end
endmodule

// File: rtl/zcb_expander.sv
// Top of the Zcb expander: decodes a 16-bit word, builds the memory or
// arithmetic expansion, and flags encodings that are outside the subset
// or disabled by configuration. Output is zero when illegal.
// Assumes: combinational, no clock or reset; XLEN is 32 or 64.
module zcb_expander
    import zcb_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit EN_MUL      = 1'b1,
    parameter bit EN_BITMANIP = 1'b1
) (
    input  logic [15:0] c_word_i,
    output logic [31:0] x_word_o,
    output logic        illegal_o
);
    zcb_kind_e         kind;
    logic [CREG_W-1:0] reg_a;
    logic [CREG_W-1:0] reg_b;
    logic [1:0]        off;
    logic [31:0]       mem_word;
    logic [31:0]       alu_word;

    zcb_field_decode #(
        .XLEN(XLEN), .EN_MUL(EN_MUL), .EN_BITMANIP(EN_BITMANIP)
    ) u_dec (
        .c_word(c_word_i), .kind(kind), .reg_a(reg_a), .reg_b(reg_b), .off(off)
    );

    zcb_mem_form u_mem (
        .kind(kind), .reg_a(reg_a), .reg_b(reg_b), .off(off), .word(mem_word)
    );

    zcb_arith_form #(.XLEN(XLEN)) u_alu (
        .kind(kind), .reg_a(reg_a), .reg_b(reg_b), .word(alu_word)
    );

    // Pick the expansion and zero it for illegal words.
    always_comb begin
        illegal_o = (kind == K_NONE);
        if (illegal_o)              x_word_o = 32'b0;
        else if (is_mem_kind(kind)) x_word_o = mem_word;
        else                        x_word_o = alu_word;
    end
endmodule

// File: rtl/zcb_expander_chk.sv
// Checker for zcb_expander: relates the compressed input to the expanded
// output and the configuration with immediate assertions.
// Assumes: bound to every zcb_expander instance.
module zcb_expander_chk #(
    parameter int XLEN        = 32,
    parameter bit EN_MUL      = 1'b1,
    parameter bit EN_BITMANIP = 1'b1
) (
    input logic [15:0] c_word_i,
    input logic [31:0] x_word_o,
    input logic        illegal_o
);
    logic [6:0] opc;
    logic [6:0] f7;
    logic [2:0] f3;

    // Fields of the expanded word.
    always_comb begin
        opc = x_word_o[6:0];
        f7  = x_word_o[31:25];
        f3  = x_word_o[14:12];
    end

    // Properties between input, output and configuration.
    always_comb begin
        // R1: rs1 is always one of x8..x15 in a legal expansion
        a_r1_base_reg: assert (illegal_o || x_word_o[19:18] == 2'b01);
        // R10: illegal words come out as zero; quadrants 2 and 3 are illegal
        a_r10_zero_when_illegal: assert (!illegal_o || x_word_o == 32'b0);
        a_r10_quadrant: assert (c_word_i[1:0] == 2'b00 || c_word_i[1:0] == 2'b01 || illegal_o);
        // R2: loads carry a small offset and only lbu/lh/lhu widths
        a_r2_load_shape: assert (illegal_o || opc != 7'b0000011 ||
                                 (x_word_o[31:22] == 10'b0 && (f3 == 3'b100 || f3 == 3'b101 || f3 == 3'b001)));
        // R4: the reserved halfword store never expands
        a_r4_sh_reserved: assert (!(c_word_i[1:0] == 2'b00 && c_word_i[15:10] == 6'b100011 && c_word_i[6]) || illegal_o);
        // R9: no multiply without the M extension
        a_r9_mul_gate: assert (EN_MUL || !(opc == 7'b0110011 && f7 == 7'b0000001));
        // R7: no bit-manipulation encodings when disabled
        a_r7_bm_gate: assert (EN_BITMANIP || (f7 != 7'b0110000 && f7 != 7'b0000100));
        // R8: zext.w never appears on a 32-bit datapath
        a_r8_w_gate: assert (XLEN == 64 || illegal_o || opc != 7'b0111011);
    end
endmodule

bind zcb_expander zcb_expander_chk #(
    .XLEN(XLEN), .EN_MUL(EN_MUL), .EN_BITMANIP(EN_BITMANIP)
) u_chk (
    .c_word_i(c_word_i), .x_word_o(x_word_o), .illegal_o(illegal_o)
);

// File: tb/zcb_expander_tb_top.sv
// Bench for zcb_expander: three configurations driven with the same
// words, compared against a bench model built from the requirements.
module zcb_expander_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] c_word = 16'h0;
    logic [31:0] w_a, w_w, w_n;
    logic        i_a, i_w, i_n;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zcb_expander #(.XLEN(32), .EN_MUL(1'b1), .EN_BITMANIP(1'b1)) dut_i (
        .c_word_i(c_word), .x_word_o(w_a), .illegal_o(i_a));
    zcb_expander #(.XLEN(64), .EN_MUL(1'b1), .EN_BITMANIP(1'b1)) dut_w_i (
        .c_word_i(c_word), .x_word_o(w_w), .illegal_o(i_w));
    zcb_expander #(.XLEN(32), .EN_MUL(1'b0), .EN_BITMANIP(1'b0)) dut_n_i (
        .c_word_i(c_word), .x_word_o(w_n), .illegal_o(i_n));

    function automatic logic [31:0] i_fmt(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] r_fmt(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    // Returns {illegal, word}.
    function automatic logic [32:0] model(input logic [15:0] c, input int xl,
                                          input bit m_on, input bit b_on);
        logic [4:0]  ra  = 5'd8 + {2'b0, c[9:7]};
        logic [4:0]  rb  = 5'd8 + {2'b0, c[4:2]};
        logic [11:0] ob  = 12'(c[5]) * 12'd2 + 12'(c[6]);
        logic [11:0] oh  = 12'(c[5]) * 12'd2;
        logic [32:0] bad = {1'b1, 32'h0};
        if (c[1:0] == 2'b00) begin
            case (c[15:10])
                6'b100000: return {1'b0, i_fmt(ob, ra, 3'b100, rb, 7'h03)};
                6'b100001: return {1'b0, i_fmt(oh, ra, c[6] ? 3'b001 : 3'b101, rb, 7'h03)};
                6'b100010: return {1'b0, 7'b0, rb, ra, 3'b000, ob[4:0], 7'h23};
                6'b100011: return c[6] ? bad : {1'b0, 7'b0, rb, ra, 3'b001, oh[4:0], 7'h23};
                default:   return bad;
            endcase
        end
        if (c[1:0] != 2'b01 || c[15:10] != 6'b100111) return bad;
        if (c[6:5] == 2'b10)
            return m_on ? {1'b0, r_fmt(7'h01, rb, ra, 3'b000, ra, 7'h33)} : bad;
        if (c[6:5] != 2'b11) return bad;
        case (c[4:2])
            3'd0: return {1'b0, i_fmt(12'd255, ra, 3'b111, ra, 7'h13)};
            3'd1: return b_on ? {1'b0, r_fmt(7'h30, 5'd4, ra, 3'b001, ra, 7'h13)} : bad;
            3'd2: return b_on ? {1'b0, r_fmt(7'h04, 5'd0, ra, 3'b100, ra,
                                            (xl == 64) ? 7'h3B : 7'h33)} : bad;
            3'd3: return b_on ? {1'b0, r_fmt(7'h30, 5'd5, ra, 3'b001, ra, 7'h13)} : bad;
            3'd4: return (b_on && xl == 64) ? {1'b0, r_fmt(7'h04, 5'd0, ra, 3'b000, ra, 7'h3B)} : bad;
            3'd5: return {1'b0, i_fmt(12'hFFF, ra, 3'b100, ra, 7'h13)};
            default: return bad;
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] c);
        if (c[1:0] == 2'b00 && c[15:10] == 6'b100001) return "R2";
        if (c[1:0] == 2'b00 && (c[15:10] == 6'b100000 || c[15:10] == 6'b100010)) return "R3";
        if (c[1:0] == 2'b00 && c[15:10] == 6'b100011) return "R4";
        if (c[1:0] == 2'b01 && c[15:10] == 6'b100111 && c[6:5] == 2'b10) return "R9";
        if (c[1:0] == 2'b01 && c[15:10] == 6'b100111 && c[6:5] == 2'b11) begin
            case (c[4:2])
                3'd0: return "R5";
                3'd5: return "R6";
                3'd4: return "R8";
                3'd1, 3'd2, 3'd3: return "R7";
                default: return "R10";
            endcase
        end
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [32:0] got, input logic [32:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s in=%h: got ill=%0b word=%h, expected ill=%0b word=%h",
                     tag, what, c_word, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Drive one word, then compare all three configurations on the falling edge.
    task automatic apply(input logic [15:0] c, input string tag);
        @(posedge clk);
        c_word = c;
        @(negedge clk);
        check(tag, "cfg32", {i_a, w_a}, model(c, 32, 1'b1, 1'b1));
        check(tag, "cfg64", {i_w, w_w}, model(c, 64, 1'b1, 1'b1));
        check(tag, "cfgoff", {i_n, w_n}, model(c, 32, 1'b0, 1'b0));
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: all-zero word (also the idle state)
        @(negedge clk);
        check("R10", "zero word", {i_a, w_a}, {1'b1, 32'h0});
        // R5: zext.b x8 literal, legal even with extensions off
        apply(16'h9C61, "R5");
        @(negedge clk);
        check("R5", "zext.b literal", {i_n, w_n}, {1'b0, 32'h0FF47413});
        // R6: not x9 literal
        apply(16'h9CF5, "R6");
        @(negedge clk);
        check("R6", "not literal", {i_a, w_a}, {1'b0, 32'hFFF4C493});
        // R3: byte offsets 1 and 2 distinguish bit order
        apply({6'b100000, 3'd7, 2'b10, 3'd0, 2'b00}, "R3");
        apply({6'b100010, 3'd2, 2'b01, 3'd5, 2'b00}, "R3");
        // R2: signed halfword load with offset 2, R1 register x15
        apply({6'b100001, 3'd7, 2'b11, 3'd7, 2'b00}, "R2");
        apply({6'b100001, 3'd0, 2'b01, 3'd1, 2'b00}, "R1");
        // R4: reserved halfword store and a legal one
        apply({6'b100011, 3'd3, 2'b10, 3'd4, 2'b00}, "R4");
        apply({6'b100011, 3'd3, 2'b01, 3'd4, 2'b00}, "R4");
        // R7 R8 R9: gated forms on all configurations
        apply({6'b100111, 3'd2, 2'b11, 3'd2, 2'b01}, "R7");
        apply({6'b100111, 3'd6, 2'b11, 3'd4, 2'b01}, "R8");
        apply({6'b100111, 3'd1, 2'b10, 3'd6, 2'b01}, "R9");
        // R10: unary sub-codes 6 and 7, quadrant 2
        apply({6'b100111, 3'd0, 2'b11, 3'd6, 2'b01}, "R10");
        apply({6'b100111, 3'd0, 2'b11, 3'd7, 2'b01}, "R10");
        apply({6'b100000, 3'd0, 2'b00, 3'd0, 2'b10}, "R10");
        // Random: half constrained to the subset, half unconstrained
        for (int k = 0; k < N_RANDOM; k++) begin
            logic [15:0] c = 16'($urandom);
            if (k % 2 == 0) begin
                logic [2:0] pick = 3'($urandom_range(0, 4));
                c[15:10] = (pick == 3'd4) ? 6'b100111 : {4'b1000, pick[1:0]};
                c[1:0]   = (pick == 3'd4) ? 2'b01 : 2'b00;
            end
            apply(c, tag_of(c));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule